// File: doc/BRIEF.md
# XGMII Receive Error Monitor

The monitor observes a 64-bit XGMII receive path. Each clock carries eight octet lanes, and every lane has its own control flag. The eight lanes form two four-lane columns. The monitor walks the lanes in order from lane 0 to lane 7. While it does so it tracks whether the stream is inside a frame, from a Start character up to a Terminate character. It keeps three saturating error counters:

- frames that carry at least one receive-error symbol;
- frame-structure faults: a misplaced Start, a bad or missing delimiter, an unexpected control character inside a frame, or a restart;
- stray control characters that arrive outside any frame.

The monitor does not decode the payload, check the FCS or handle link fault signalling. The counters are meant to be sampled by surrounding logic. A synchronous clear input zeroes all three counters.

Top module: `xgmii_rx_err_mon`

## Requirements
- R1: Lane i is `rxd[8i+7:8i]` with control flag `rxc[i]`. The control codes are Start 0xFB, Terminate 0xFD, Idle 0x07 and Error 0xFE. A Start in lane 0 or lane 4 outside a frame opens a frame. A Terminate inside a frame closes it. `in_frame` shows the frame state after the last column received.
- R2: An Error symbol inside a frame, including the Start and Terminate columns, adds one to `sym_err_cnt`. This happens only once per frame, however many Error symbols the frame carries.
- R3: A Start in any lane other than 0 or 4 adds one to `data_err_cnt`. It leaves the frame state unchanged and does not touch `ctrl_err_cnt`.
- R4: The octet seven lanes after a valid Start must be the data octet 0xD5. If it is not, `data_err_cnt` is incremented. For a Start in lane 4, that octet is lane 3 of the next column, so the error is counted one cycle later.
- R5: Inside a frame, a control character other than Start, Terminate or Error adds one to `data_err_cnt` and closes the frame.
- R6: A Start in lane 0 or lane 4 while already inside a frame adds one to `data_err_cnt` and opens a new frame. The new frame's once-per-frame Error allowance is fresh.
- R7: Outside a frame, a control character other than Idle or Start adds one to `ctrl_err_cnt` and nothing to `data_err_cnt`. Idle and data octets outside a frame change no counter.
- R8: All errors found in one column are summed into their counters. The sums appear on the outputs after the clock edge that samples that column.
- R9: Each counter saturates at its all-ones value (2^CNT_W-1).
- R10: When `clr` is high, all counters read zero after the next edge, and any increments from that column are dropped. The frame state is unaffected.
- R11: After reset, all counters are zero and `in_frame` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the counters |
| rxd | input | 64 | Receive data, eight octet lanes |
| rxc | input | 8 | Receive control flags, one per lane |
| in_frame | output | 1 | High while inside a frame |
| sym_err_cnt | output | CNT_W | Frames containing an Error symbol |
| data_err_cnt | output | CNT_W | Frame-structure errors |
| ctrl_err_cnt | output | CNT_W | Stray control characters outside frames |

## Verification
Every counter and `in_frame` is a single register stage after the column that causes the change. The bench therefore drives each column one nanosecond after a rising edge and reads the outputs one nanosecond after the following edge. The delimiter check for a Start in lane 4 is due one column later. The bench checks that the data counter is still unchanged after the Start column and has risen after the next one. Saturation is run with a narrow counter width, so the cap is reached within a few columns, and it is checked on the cycle that crosses the limit as well as on the cycle after.

// File: rtl/xrem_pkg.sv
package xrem_pkg;
    localparam int XR_LANES   = 8;
    localparam int XR_COL     = 4;
    localparam int XR_SFD_OFS = 7;
    localparam int XR_LANE_IW = $clog2(XR_LANES);
    localparam int XR_INC_W   = $clog2(XR_LANES + 1);

    localparam logic [7:0] XR_START = 8'hFB;
    localparam logic [7:0] XR_TERM  = 8'hFD;
    localparam logic [7:0] XR_IDLE  = 8'h07;
    localparam logic [7:0] XR_ERR   = 8'hFE;
    localparam logic [7:0] XR_SFD   = 8'hD5;

    typedef logic [XR_LANE_IW-1:0] lane_idx_t;

    typedef struct packed {
        logic      in_frame;
        logic      sym_seen;
        logic      pend_v;
        lane_idx_t pend_lane;
    } frame_st_t;
endpackage

// File: rtl/xrem_lane_scan.sv
module xrem_lane_scan
    import xrem_pkg::*;
(
    input  logic [XR_LANES*8-1:0] rxd,
    input  logic [XR_LANES-1:0]   rxc,
    input  frame_st_t             st_i,
    output frame_st_t             st_o,
    output logic [XR_INC_W-1:0]   sym_inc,
    output logic [XR_INC_W-1:0]   data_inc,
    output logic [XR_INC_W-1:0]   ctrl_inc
);
    frame_st_t  s;
    logic       due_v;
    lane_idx_t  due_l;
    logic [7:0] oct;
    logic       ctl;

    always_comb begin
        s           = st_i;
        due_v       = st_i.pend_v;
        due_l       = st_i.pend_lane;
        s.pend_v    = 1'b0;
        s.pend_lane = '0;
        sym_inc     = '0;
        data_inc    = '0;
        ctrl_inc    = '0;
        oct         = '0;
        ctl         = 1'b0;
        for (int i = 0; i < XR_LANES; i++) begin
            oct = rxd[8*i +: 8];
            ctl = rxc[i];
            // delimiter position owed by an earlier Start
            if (due_v && due_l == lane_idx_t'(i)) begin
                due_v = 1'b0;
                if (ctl || oct != XR_SFD)
                    data_inc = data_inc + XR_INC_W'(1);
            end
            if (ctl) begin
                if (oct == XR_START) begin
                    if (i % XR_COL != 0) begin
                        data_inc = data_inc + XR_INC_W'(1);
                    end else begin
                        if (s.in_frame)
                            data_inc = data_inc + XR_INC_W'(1);
                        s.in_frame = 1'b1;
                        s.sym_seen = 1'b0;
                        if (i + XR_SFD_OFS < XR_LANES) begin
                            due_v       = 1'b1;
                            due_l       = lane_idx_t'(i + XR_SFD_OFS);
                            s.pend_v    = 1'b0;
                        end else begin
                            due_v       = 1'b0;
                            s.pend_v    = 1'b1;
                            s.pend_lane = lane_idx_t'(i + XR_SFD_OFS - XR_LANES);
                        end
                    end
                end else if (s.in_frame) begin
                    if (oct == XR_ERR) begin
                        if (!s.sym_seen) begin
                            sym_inc    = sym_inc + XR_INC_W'(1);
                            s.sym_seen = 1'b1;
                        end
                    end else begin
                        if (oct != XR_TERM)
                            data_inc = data_inc + XR_INC_W'(1);
                        s.in_frame = 1'b0;
                        s.sym_seen = 1'b0;
                        s.pend_v   = 1'b0;
                        due_v      = 1'b0;
                    end
                end else if (oct != XR_IDLE) begin
                    ctrl_inc = ctrl_inc + XR_INC_W'(1);
                end
            end
        end
        st_o = s;
    end
endmodule

// File: rtl/xrem_sat_cnt.sv
module xrem_sat_cnt #(
    parameter int CNT_W = 32,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W:0] LIMIT = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum = {1'b0, cnt_q} + (CNT_W+1)'(inc);
        if (clr)
            cnt_d = '0;
        else if (sum > LIMIT)
            cnt_d = LIMIT[CNT_W-1:0];
        else
            cnt_d = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/xgmii_rx_err_mon.sv
module xgmii_rx_err_mon
    import xrem_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [XR_LANES*8-1:0] rxd,
    input  logic [XR_LANES-1:0]   rxc,
    output logic                  in_frame,
    output logic [CNT_W-1:0]      sym_err_cnt,
    output logic [CNT_W-1:0]      data_err_cnt,
    output logic [CNT_W-1:0]      ctrl_err_cnt
);
    localparam int N_CNT = 3;

    frame_st_t st_d, st_q, st_nx;
    logic [XR_INC_W-1:0] inc_a [N_CNT];
    logic [CNT_W-1:0]    cnt_a [N_CNT];

    xrem_lane_scan i_scan (
        .rxd      (rxd),
        .rxc      (rxc),
        .st_i     (st_q),
        .st_o     (st_nx),
        .sym_inc  (inc_a[0]),
        .data_inc (inc_a[1]),
        .ctrl_inc (inc_a[2])
    );

    always_comb begin
        st_d = st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        xrem_sat_cnt #(.CNT_W(CNT_W), .INC_W(XR_INC_W)) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc_a[g]),
            .cnt   (cnt_a[g])
        );
    end

    assign in_frame     = st_q.in_frame;
    assign sym_err_cnt  = cnt_a[0];
    assign data_err_cnt = cnt_a[1];
    assign ctrl_err_cnt = cnt_a[2];
endmodule

// File: rtl/xrem_checker.sv
module xrem_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic [63:0]      rxd,
    input logic [7:0]       rxc,
    input logic             in_frame,
    input logic [CNT_W-1:0] sym_err_cnt,
    input logic [CNT_W-1:0] data_err_cnt,
    input logic [CNT_W-1:0] ctrl_err_cnt
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sym_err_cnt == '0 && data_err_cnt == '0 && ctrl_err_cnt == '0)); // R10

    AST_CLEAR_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && rxc == 8'h00) |=> $stable(in_frame)); // R10

    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ctrl_err_cnt == TOP) |=> ctrl_err_cnt == TOP); // R9

    AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (data_err_cnt >= $past(data_err_cnt) && sym_err_cnt >= $past(sym_err_cnt))); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !in_frame && rxc == 8'hFF && rxd == {8{8'h07}})
        |=> ($stable(data_err_cnt) && $stable(ctrl_err_cnt) && $stable(sym_err_cnt) && !in_frame)); // R7

    AST_DATA_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !in_frame && rxc == 8'h00)
        |=> ($stable(data_err_cnt) && $stable(ctrl_err_cnt) && $stable(sym_err_cnt))); // R7

    AST_SYM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && in_frame && rxc == 8'h00) |=> $stable(sym_err_cnt)); // R2
endmodule

bind xgmii_rx_err_mon xrem_checker #(.CNT_W(CNT_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .rxd          (rxd),
    .rxc          (rxc),
    .in_frame     (in_frame),
    .sym_err_cnt  (sym_err_cnt),
    .data_err_cnt (data_err_cnt),
    .ctrl_err_cnt (ctrl_err_cnt)
);

// File: tb/test_xgmii_rx_err_mon.sv
`timescale 1ns/1ps
module test_xgmii_rx_err_mon;
    localparam int CW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic [63:0] rxd = {8{8'h07}};
    logic [7:0]  rxc = 8'hFF;
    logic in_frame;
    logic [CW-1:0] sym_c, data_c, ctrl_c;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [63:0] D_IDLE  = {8{8'h07}};
    localparam logic [63:0] D_SOF0  = 64'hD5555555_555555FB;
    localparam logic [63:0] D_TERM0 = 64'h07070707_070707FD;

    always #2 clk = ~clk;

    xgmii_rx_err_mon #(.CNT_W(CW)) i_xgmii_rx_err_mon (
        .clk(clk), .rst_n(rst_n), .clr(clr), .rxd(rxd), .rxc(rxc),
        .in_frame(in_frame), .sym_err_cnt(sym_c), .data_err_cnt(data_c),
        .ctrl_err_cnt(ctrl_c)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input int s, input int d, input int c, input int f);
        chk({req, " sym"}, int'(sym_c), s);
        chk({req, " data"}, int'(data_c), d);
        chk({req, " ctrl"}, int'(ctrl_c), c);
        chk({req, " in_frame"}, int'(in_frame), f);
    endtask

    // drive one column 1 ns after an edge; return 1 ns after the edge that samples it
    task automatic col(input logic [63:0] d, input logic [7:0] c);
        rxd = d; rxc = c;
        @(posedge clk); #1;
    endtask

    task automatic do_clear();
        clr = 1'b1;
        col(D_IDLE, 8'hFF);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        chk_all("R11 reset", 0, 0, 0, 0);
    endtask

    task automatic t_good_frame();
        do_clear();
        col(D_SOF0, 8'h01);
        chk("R1 open", int'(in_frame), 1);
        col(64'h01234567_89ABCDEF, 8'h00);
        col(D_TERM0, 8'hFF);
        chk_all("R1 clean frame", 0, 0, 0, 0);
    endtask

    task automatic t_sym_once();
        do_clear();
        col(D_SOF0, 8'h01);
        col(64'h0000FE00_00FE0000, 8'h24);
        chk("R2 first error", int'(sym_c), 1);
        col(64'h00000000_000000FE, 8'h01);
        col(D_TERM0, 8'hFF);
        chk_all("R2 once per frame", 1, 0, 0, 0);
        col(D_SOF0, 8'h01);
        col(64'h07070707_0707FDFE, 8'hFF);
        chk_all("R2 error in terminate column", 2, 0, 0, 0);
    endtask

    task automatic t_misplaced_start();
        do_clear();
        col(64'h07070707_07FB0707, 8'hFF);
        chk_all("R3 misplaced start", 0, 1, 0, 0);
    endtask

    task automatic t_bad_sfd_lane0();
        do_clear();
        col(64'h55555555_555555FB, 8'h01);
        chk_all("R4 bad delimiter lane0", 0, 1, 0, 1);
        col(D_TERM0, 8'hFF);
    endtask

    task automatic t_sfd_lane4();
        do_clear();
        col(64'h555555FB_07070707, 8'h1F);
        chk_all("R4 lane4 start pending", 0, 0, 0, 1);
        col(64'h00000000_D5555555, 8'h00);
        chk("R4 lane4 good delimiter", int'(data_c), 0);
        col(D_TERM0, 8'hFF);
        col(64'h555555FB_07070707, 8'h1F);
        chk("R8 lane4 error not yet due", int'(data_c), 0);
        col(64'h00000000_55555555, 8'h00);
        chk("R4 lane4 bad delimiter next column", int'(data_c), 1);
        col(D_TERM0, 8'hFF);
    endtask

    task automatic t_bad_ctrl_in_frame();
        do_clear();
        col(D_SOF0, 8'h01);
        col(64'h00000000_07000000, 8'h08);
        chk_all("R5 unexpected control in frame", 0, 1, 0, 0);
    endtask

    task automatic t_restart();
        do_clear();
        col(D_SOF0, 8'h01);
        col(64'h00000000_0000FE00, 8'h02);
        col(D_SOF0, 8'h01);
        chk_all("R6 restart", 1, 1, 0, 1);
        col(64'h00000000_0000FE00, 8'h02);
        col(D_TERM0, 8'hFF);
        chk_all("R6 fresh allowance", 2, 1, 0, 0);
    endtask

    task automatic t_ctrl_outside();
        do_clear();
        col(64'h07070707_0707FEFD, 8'hFF);
        chk_all("R7 stray terminate and error", 0, 0, 2, 0);
        col(64'h12345678_9ABCDEF0, 8'h00);
        chk_all("R7 data outside ignored", 0, 0, 2, 0);
        col(64'h07070707_0707079C, 8'hFF);
        chk("R7 other control outside", int'(ctrl_c), 3);
    endtask

    task automatic t_multi();
        do_clear();
        col(64'h0707FD07_07FBFB07, 8'hFF);
        chk_all("R8 several in one column", 0, 2, 1, 0);
    endtask

    task automatic t_saturate();
        do_clear();
        for (int k = 0; k < 7; k++) col({8{8'hFD}}, 8'hFF);
        chk("R9 below cap", int'(ctrl_c), 56);
        col({8{8'hFD}}, 8'hFF);
        chk("R9 capped", int'(ctrl_c), 63);
        col({8{8'hFD}}, 8'hFF);
        chk("R9 stays capped", int'(ctrl_c), 63);
    endtask

    task automatic t_clear();
        do_clear();
        col({8{8'hFD}}, 8'hFF);
        col(D_SOF0, 8'h01);
        chk("R10 pre-clear", int'(ctrl_c), 8);
        clr = 1'b1;
        col(64'h00000000_00FB0000, 8'h04);
        clr = 1'b0;
        chk_all("R10 clear wins, frame kept", 0, 0, 0, 1);
        col(D_TERM0, 8'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_good_frame();
        t_sym_once();
        t_misplaced_start();
        t_bad_sfd_lane0();
        t_sfd_lane4();
        t_bad_ctrl_in_frame();
        t_restart();
        t_ctrl_outside();
        t_multi();
        t_saturate();
        t_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule